// File: doc/BRIEF.md
# Chained Event Counter Bank

This block keeps a set of programmable event counters beside one free-running cycle counter. Each event counter holds a type code. Every clock the block may receive one event number from the surrounding logic. Each enabled counter whose type equals that number advances by one. A write to a software-increment mask advances the counters that are programmed with the software type code. An overflow sets a sticky status bit. The overflow of an even counter can also be passed as a carry to its odd neighbour, so that a pair of 32-bit counters can be used as one longer count.

The number of event counters, the width of the type code and the width of the event counters are parameters. The cycle counter always sits at index 31. All register updates are synchronous. The read port is combinational: it shows the value and the type of the counter selected by `rd_idx`. Privilege filtering, bus decoding and interrupt signalling belong to the surrounding logic.

Top module: `evt_counter_bank`

## Requirements
- R1: No counter advances and no status bit is set while `glb_en` is low. This holds for external events, software increments, chain carries and the cycle counter.
- R2: A write on the enable port with `en_set`=1 ORs `en_mask` into `cnt_en`, and a write with `en_set`=0 clears the masked bits. Bit i enables counter i, and bit 31 enables the cycle counter. Bits for counters that are not implemented always read 0. A counter whose enable bit is 0 does not count.
- R3: When `evt_valid` is high and `evt_num` equals the stored type exactly, an enabled event counter advances by one. This applies to every type other than 16'h0000 and 16'h001E.
- R4: A type write stores `typ_wdata` masked to the supported width: 10 bits when `WIDE_EVT`=0 and 16 bits when it is 1. Type writes to index 31 or to an unimplemented index are ignored, and `rd_type` reads 0 at those indices.
- R5: When `WIDE_CNT`=0 the event counters are 32 bits wide. A load keeps only the low 32 bits, an increment wraps at 2^32, and the upper half of `rd_value` reads 0.
- R6: With `evt_long` low, an event counter overflows when an increment makes its low 32 bits zero. With `evt_long` high, and only when `WIDE_CNT`=1, it overflows when the full 64-bit value wraps to zero. An overflow sets status bit i at the same clock edge, and the bit stays set until reset.
- R7: The cycle counter (index 31) is 64 bits wide. It advances once per clock while `glb_en` and `cnt_en[31]` are high, and it ignores event numbers, type writes and software increments. It overflows when its low 32 bits wrap, or when the full 64 bits wrap if `cyc_long` is high, and it then sets status bit 31.
- R8: An overflow of even counter i, where i+1 is an implemented event counter and 64-bit overflow is not in effect, gives one increment to counter i+1 at the same clock edge, provided counter i+1 has type 16'h001E and is enabled. With 64-bit overflow in effect, no chain carry is sent.
- R9: A cycle with `swinc_valid` high advances by one every enabled event counter that has type 16'h0000 and its bit set in `swinc_mask`.
- R10: The event numbers 16'h0000 and 16'h001E on `evt_num` advance no counter.
- R11: Reset clears every counter, type, enable bit and status bit. A load through `cnt_wr` takes priority over an increment in the same cycle and never sets a status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glb_en | input | 1 | Global count enable |
| evt_long | input | 1 | Event counters overflow at 64 bits (used only when WIDE_CNT=1) |
| cyc_long | input | 1 | Cycle counter overflows at 64 bits |
| evt_valid | input | 1 | An event is present this cycle |
| evt_num | input | 16 | Number of the incoming event |
| swinc_valid | input | 1 | Software-increment write strobe |
| swinc_mask | input | NUM_EVT | Counters that receive the software increment |
| en_wr | input | 1 | Enable register write strobe |
| en_set | input | 1 | 1: set the masked bits, 0: clear them |
| en_mask | input | 32 | Enable bits to change |
| wr_idx | input | 5 | Target index for type and count writes |
| typ_wr | input | 1 | Type write strobe |
| typ_wdata | input | 16 | Type code to store |
| cnt_wr | input | 1 | Counter load strobe |
| cnt_wdata | input | 64 | Counter load value |
| rd_idx | input | 5 | Counter selected for reading |
| rd_value | output | 64 | Value of the selected counter |
| rd_type | output | 16 | Type of the selected counter |
| cnt_en | output | 32 | Enable register |
| ovf_status | output | 32 | Sticky overflow status |

## Verification
Every effect of a stimulus appears at the clock edge that samples it. This covers the increment, the status bit, the chain carry into the odd neighbour, and any load, type write or enable write. No result is delayed by a further cycle. Because the read port is combinational, the new value can be read in the low phase that follows that edge. The bench drives inputs on the falling edge, runs one behavioural model per instance on the rising edge, and compares late in the low phase. Directed reads of single counters are made one nanosecond after the falling edge.

// File: rtl/evb_pkg.sv
package evb_pkg;
   timeunit 1ns;
   timeprecision 1ns;

   localparam int CYC_IDX = 31;
   localparam int IDX_W   = 5;
   localparam int TYPE_W  = 16;
   localparam int VAL_W   = 64;

   localparam logic [TYPE_W-1:0] EV_SOFT  = 16'h0000;
   localparam logic [TYPE_W-1:0] EV_CHAIN = 16'h001E;

   typedef enum logic [1:0] {
      SRC_SOFT,
      SRC_CHAIN,
      SRC_EXT
   } src_e;

   function automatic logic [TYPE_W-1:0] type_mask(input bit wide);
      return wide ? 16'hFFFF : 16'h03FF;
   endfunction
endpackage

// File: rtl/evb_event_counter.sv
module evb_event_counter
   import evb_pkg::*;
#(
   parameter bit  WIDE_CNT = 1'b0,
   parameter bit  WIDE_EVT = 1'b1,
   localparam int CW       = WIDE_CNT ? 64 : 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              long_ovf,
   input  logic              evt_valid,
   input  logic [TYPE_W-1:0] evt_num,
   input  logic              sw_req,
   input  logic              chain_req,
   input  logic              type_we,
   input  logic [TYPE_W-1:0] type_din,
   input  logic              load_we,
   input  logic [CW-1:0]     load_din,
   output logic [TYPE_W-1:0] type_q,
   output logic [VAL_W-1:0]  value,
   output logic              ovf
);
   timeunit 1ns;
   timeprecision 1ns;

   localparam logic [TYPE_W-1:0] TMASK = type_mask(WIDE_EVT);

   logic [CW-1:0] cnt;
   logic [CW-1:0] sum;
   src_e          src;
   logic          hit_raw;
   logic          hit;

   always_comb begin
      case (type_q)
         EV_SOFT:  src = SRC_SOFT;
         EV_CHAIN: src = SRC_CHAIN;
         default:  src = SRC_EXT;
      endcase
   end

   always_comb begin
      case (src)
         SRC_SOFT:  hit_raw = sw_req;
         SRC_CHAIN: hit_raw = chain_req;
         default:   hit_raw = evt_valid && (evt_num == type_q);
      endcase
   end

   assign hit = active && hit_raw;
   assign sum = cnt + CW'(1);
   assign ovf = hit && !load_we &&
                (long_ovf ? (sum == '0) : (sum[31:0] == 32'd0));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         type_q <= '0;
      end else begin
         if (type_we) type_q <= type_din & TMASK;
         if (load_we)  cnt <= load_din;
         else if (hit) cnt <= sum;
      end
   end

   assign value = VAL_W'(cnt);

   assert_idle_hold_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !load_we) |=> $stable(value));

   assert_wrap_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> (value[31:0] == 32'd0));
endmodule

// File: rtl/evb_cycle_counter.sv
module evb_cycle_counter
   import evb_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             long_ovf,
   input  logic             load_we,
   input  logic [VAL_W-1:0] load_din,
   output logic [VAL_W-1:0] value,
   output logic             ovf
);
   timeunit 1ns;
   timeprecision 1ns;

   logic [VAL_W-1:0] sum;

   assign sum = value + 64'd1;
   assign ovf = active && !load_we &&
                (long_ovf ? (sum == '0) : (sum[31:0] == 32'd0));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       value <= '0;
      else if (load_we) value <= load_din;
      else if (active)  value <= sum;
   end

   assert_cyc_step_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (active && !load_we) |=> (value == $past(value) + 64'd1));
endmodule

// File: rtl/evt_counter_bank.sv
module evt_counter_bank
   import evb_pkg::*;
#(
   parameter int NUM_EVT  = 6,
   parameter bit WIDE_EVT = 1'b1,
   parameter bit WIDE_CNT = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               glb_en,
   input  logic               evt_long,
   input  logic               cyc_long,
   input  logic               evt_valid,
   input  logic [15:0]        evt_num,
   input  logic               swinc_valid,
   input  logic [NUM_EVT-1:0] swinc_mask,
   input  logic               en_wr,
   input  logic               en_set,
   input  logic [31:0]        en_mask,
   input  logic [4:0]         wr_idx,
   input  logic               typ_wr,
   input  logic [15:0]        typ_wdata,
   input  logic               cnt_wr,
   input  logic [63:0]        cnt_wdata,
   input  logic [4:0]         rd_idx,
   output logic [63:0]        rd_value,
   output logic [15:0]        rd_type,
   output logic [31:0]        cnt_en,
   output logic [31:0]        ovf_status
);
   timeunit 1ns;
   timeprecision 1ns;

   localparam int          EV_CW = WIDE_CNT ? 64 : 32;
   localparam logic [31:0] VALID = ((32'd1 << NUM_EVT) - 32'd1) | (32'd1 << CYC_IDX);

   generate
      if (NUM_EVT < 1 || NUM_EVT > CYC_IDX) begin : g_bad_count
         $error("evt_counter_bank: NUM_EVT must be within 1..31");
      end
   endgenerate

   logic [VAL_W-1:0]  val [32];
   logic [TYPE_W-1:0] typ [32];
   logic [31:0]       ovf_vec;
   logic              evt_long_eff;

   assign evt_long_eff = evt_long & WIDE_CNT;

   for (genvar i = 0; i < CYC_IDX; i++) begin : g_slot
      if (i < NUM_EVT) begin : g_impl
         logic chain_in;
         if (i % 2 == 1) begin : g_odd
            assign chain_in = ovf_vec[i-1] && !evt_long_eff;

            assert_chain_R8 : assert property (@(posedge clk) disable iff (!rst_n)
               (ovf_vec[i-1] && !evt_long_eff && glb_en && cnt_en[i] &&
                typ[i] == EV_CHAIN && !(cnt_wr && wr_idx == IDX_W'(i)))
               |=> (val[i][31:0] == $past(val[i][31:0]) + 32'd1));
         end else begin : g_even
            assign chain_in = 1'b0;
         end

         evb_event_counter #(
            .WIDE_CNT (WIDE_CNT),
            .WIDE_EVT (WIDE_EVT)
         ) i_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .active    (glb_en && cnt_en[i]),
            .long_ovf  (evt_long_eff),
            .evt_valid (evt_valid),
            .evt_num   (evt_num),
            .sw_req    (swinc_valid && swinc_mask[i]),
            .chain_req (chain_in),
            .type_we   (typ_wr && wr_idx == IDX_W'(i)),
            .type_din  (typ_wdata),
            .load_we   (cnt_wr && wr_idx == IDX_W'(i)),
            .load_din  (cnt_wdata[EV_CW-1:0]),
            .type_q    (typ[i]),
            .value     (val[i]),
            .ovf       (ovf_vec[i])
         );
      end else begin : g_absent
         assign val[i]     = '0;
         assign typ[i]     = '0;
         assign ovf_vec[i] = 1'b0;
      end
   end

   evb_cycle_counter i_cyc (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (glb_en && cnt_en[CYC_IDX]),
      .long_ovf (cyc_long),
      .load_we  (cnt_wr && wr_idx == IDX_W'(CYC_IDX)),
      .load_din (cnt_wdata),
      .value    (val[CYC_IDX]),
      .ovf      (ovf_vec[CYC_IDX])
   );
   assign typ[CYC_IDX] = '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_en     <= '0;
         ovf_status <= '0;
      end else begin
         ovf_status <= ovf_status | ovf_vec;
         if (en_wr) begin
            if (en_set) cnt_en <= cnt_en | (en_mask & VALID);
            else        cnt_en <= cnt_en & ~en_mask;
         end
      end
   end

   assign rd_value = val[rd_idx];
   assign rd_type  = typ[rd_idx];

   assert_gate_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      !glb_en |=> $stable(ovf_status));
endmodule

// File: tb/test_evt_counter_bank.sv
module ref_bank #(
   parameter int N  = 6,
   parameter bit WE = 1'b1,
   parameter bit WC = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        glb_en,
   input  logic        evt_long,
   input  logic        cyc_long,
   input  logic        evt_valid,
   input  logic [15:0] evt_num,
   input  logic        swinc_valid,
   input  logic [31:0] swinc_mask,
   input  logic        en_wr,
   input  logic        en_set,
   input  logic [31:0] en_mask,
   input  logic [4:0]  wr_idx,
   input  logic        typ_wr,
   input  logic [15:0] typ_wdata,
   input  logic        cnt_wr,
   input  logic [63:0] cnt_wdata,
   input  logic [4:0]  rd_idx,
   output logic [63:0] exp_rd,
   output logic [15:0] exp_type,
   output logic [31:0] exp_en,
   output logic [31:0] exp_ovf
);
   timeunit 1ns;
   timeprecision 1ns;

   logic [63:0] v [32];
   logic [15:0] t [32];
   logic [31:0] en, ovf;

   assign exp_rd   = v[rd_idx];
   assign exp_type = t[rd_idx];
   assign exp_en   = en;
   assign exp_ovf  = ovf;

   always @(posedge clk or negedge rst_n) begin : model
      logic [63:0] nv [32];
      logic [31:0] hov, okm;
      logic [63:0] s;
      logic [15:0] msk;
      bit inc, lng, ld;
      if (!rst_n) begin
         for (int i = 0; i < 32; i++) begin v[i] = '0; t[i] = '0; end
         en = '0; ovf = '0;
      end else begin
         lng = WC && evt_long;
         msk = WE ? 16'hFFFF : 16'h03FF;
         hov = '0;
         okm = 32'h8000_0000;
         for (int i = 0; i < N; i++) okm[i] = 1'b1;
         for (int i = 0; i < 32; i++) nv[i] = v[i];
         for (int i = 0; i < N; i++) begin
            inc = 0;
            ld  = cnt_wr && (int'(wr_idx) == i);
            if (glb_en && en[i] && !ld) begin
               if (t[i] == 16'h0000) inc = swinc_valid && swinc_mask[i];
               else if (t[i] == 16'h001E) begin
                  if (i % 2 == 1) inc = !lng && hov[i-1];
               end else inc = evt_valid && (evt_num == t[i]);
            end
            if (inc) begin
               s = v[i] + 64'd1;
               if (!WC) s[63:32] = '0;
               nv[i] = s;
               if (lng ? (s == 0) : (s[31:0] == 0)) hov[i] = 1'b1;
            end
         end
         if (glb_en && en[31] && !(cnt_wr && wr_idx == 5'd31)) begin
            s = v[31] + 64'd1;
            nv[31] = s;
            if (cyc_long ? (s == 0) : (s[31:0] == 0)) hov[31] = 1'b1;
         end
         if (cnt_wr && (wr_idx == 5'd31 || int'(wr_idx) < N))
            nv[wr_idx] = (WC || wr_idx == 5'd31) ? cnt_wdata : {32'b0, cnt_wdata[31:0]};
         for (int i = 0; i < 32; i++) v[i] = nv[i];
         ovf = ovf | hov;
         if (typ_wr && int'(wr_idx) < N) t[wr_idx] = typ_wdata & msk;
         if (en_wr) en = en_set ? (en | (en_mask & okm)) : (en & ~en_mask);
      end
   end
endmodule

module test_evt_counter_bank;
   timeunit 1ns;
   timeprecision 1ns;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic        glb_en = 0, evt_long = 0, cyc_long = 0, evt_valid = 0;
   logic [15:0] evt_num = 0;
   logic        swinc_valid = 0;
   logic [31:0] sw_mask = 0;
   logic        en_wr = 0, en_set = 0;
   logic [31:0] en_mask = 0;
   logic [4:0]  wr_idx = 0, rd_idx = 0;
   logic        typ_wr = 0, cnt_wr = 0;
   logic [15:0] typ_wdata = 0;
   logic [63:0] cnt_wdata = 0;

   logic [63:0] a_rd, b_rd, ma_rd, mb_rd;
   logic [15:0] a_ty, b_ty, ma_ty, mb_ty;
   logic [31:0] a_en, b_en, ma_en, mb_en, a_ov, b_ov, ma_ov, mb_ov;

   evt_counter_bank #(.NUM_EVT(6), .WIDE_EVT(1'b0), .WIDE_CNT(1'b0)) i_evt_counter_bank (
      .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .evt_long(evt_long), .cyc_long(cyc_long),
      .evt_valid(evt_valid), .evt_num(evt_num), .swinc_valid(swinc_valid),
      .swinc_mask(sw_mask[5:0]), .en_wr(en_wr), .en_set(en_set), .en_mask(en_mask),
      .wr_idx(wr_idx), .typ_wr(typ_wr), .typ_wdata(typ_wdata), .cnt_wr(cnt_wr),
      .cnt_wdata(cnt_wdata), .rd_idx(rd_idx), .rd_value(a_rd), .rd_type(a_ty),
      .cnt_en(a_en), .ovf_status(a_ov));

   evt_counter_bank #(.NUM_EVT(5), .WIDE_EVT(1'b1), .WIDE_CNT(1'b1)) i_evt_counter_bank_b (
      .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .evt_long(evt_long), .cyc_long(cyc_long),
      .evt_valid(evt_valid), .evt_num(evt_num), .swinc_valid(swinc_valid),
      .swinc_mask(sw_mask[4:0]), .en_wr(en_wr), .en_set(en_set), .en_mask(en_mask),
      .wr_idx(wr_idx), .typ_wr(typ_wr), .typ_wdata(typ_wdata), .cnt_wr(cnt_wr),
      .cnt_wdata(cnt_wdata), .rd_idx(rd_idx), .rd_value(b_rd), .rd_type(b_ty),
      .cnt_en(b_en), .ovf_status(b_ov));

   ref_bank #(.N(6), .WE(1'b0), .WC(1'b0)) m_a (
      .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .evt_long(evt_long), .cyc_long(cyc_long),
      .evt_valid(evt_valid), .evt_num(evt_num), .swinc_valid(swinc_valid),
      .swinc_mask({26'b0, sw_mask[5:0]}), .en_wr(en_wr), .en_set(en_set), .en_mask(en_mask),
      .wr_idx(wr_idx), .typ_wr(typ_wr), .typ_wdata(typ_wdata), .cnt_wr(cnt_wr),
      .cnt_wdata(cnt_wdata), .rd_idx(rd_idx), .exp_rd(ma_rd), .exp_type(ma_ty),
      .exp_en(ma_en), .exp_ovf(ma_ov));

   ref_bank #(.N(5), .WE(1'b1), .WC(1'b1)) m_b (
      .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .evt_long(evt_long), .cyc_long(cyc_long),
      .evt_valid(evt_valid), .evt_num(evt_num), .swinc_valid(swinc_valid),
      .swinc_mask({27'b0, sw_mask[4:0]}), .en_wr(en_wr), .en_set(en_set), .en_mask(en_mask),
      .wr_idx(wr_idx), .typ_wr(typ_wr), .typ_wdata(typ_wdata), .cnt_wr(cnt_wr),
      .cnt_wdata(cnt_wdata), .rd_idx(rd_idx), .exp_rd(mb_rd), .exp_type(mb_ty),
      .exp_en(mb_en), .exp_ovf(mb_ov));

   int n_cmp = 0, n_bad = 0;
   bit run_cmp = 0, done = 0;

   task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, got, exp, $time);
      end
   endtask

   // lockstep comparison late in every low phase
   always begin
      @(negedge clk);
      #9;
      if (run_cmp) begin
         chk("R3 lockstep value A", a_rd, ma_rd);
         chk("R4 lockstep type A", {48'b0, a_ty}, {48'b0, ma_ty});
         chk("R2 lockstep enable A", {32'b0, a_en}, {32'b0, ma_en});
         chk("R6 lockstep status A", {32'b0, a_ov}, {32'b0, ma_ov});
         chk("R3 lockstep value B", b_rd, mb_rd);
         chk("R4 lockstep type B", {48'b0, b_ty}, {48'b0, mb_ty});
         chk("R2 lockstep enable B", {32'b0, b_en}, {32'b0, mb_en});
         chk("R6 lockstep status B", {32'b0, b_ov}, {32'b0, mb_ov});
      end
   end

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic pk(input string tag, input int idx, input logic [63:0] ea, input logic [63:0] eb);
      rd_idx = 5'(idx);
      #1;
      chk({tag, " A"}, a_rd, ea);
      chk({tag, " B"}, b_rd, eb);
   endtask

   task automatic ev(input logic [15:0] n);
      evt_valid = 1; evt_num = n; tick(); evt_valid = 0;
   endtask

   task automatic ld(input int idx, input logic [63:0] d);
      cnt_wr = 1; wr_idx = 5'(idx); cnt_wdata = d; tick(); cnt_wr = 0;
   endtask

   task automatic wt(input int idx, input logic [15:0] d);
      typ_wr = 1; wr_idx = 5'(idx); typ_wdata = d; tick(); typ_wr = 0;
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [63:0] v1;
      repeat (3) tick();
      rst_n = 1;
      run_cmp = 1;
      // R11: reset state
      pk("R11 reset value", 0, 64'd0, 64'd0);
      chk("R11 reset enable", {32'b0, a_en}, 64'd0);
      chk("R11 reset status", {32'b0, b_ov}, 64'd0);

      wt(0, 16'h0011); wt(1, 16'h001E); wt(2, 16'h0000);
      wt(3, 16'h1234); wt(4, 16'h0011); wt(31, 16'h0011);
      rd_idx = 5'd3; #1;
      chk("R4 type masked A", {48'b0, a_ty}, 64'h0234);
      chk("R4 type full B", {48'b0, b_ty}, 64'h1234);
      rd_idx = 5'd31; #1;
      chk("R4 cycle type ignored", {48'b0, a_ty}, 64'h0);

      en_wr = 1; en_set = 1; en_mask = 32'hFFFF_FFFF; tick(); en_wr = 0;
      chk("R2 enable range A", {32'b0, a_en}, 64'h8000_003F);
      chk("R2 enable range B", {32'b0, b_en}, 64'h8000_001F);

      ev(16'h0011);
      pk("R1 gated event", 0, 64'd0, 64'd0);
      pk("R1 gated cycle", 31, 64'd0, 64'd0);

      glb_en = 1; tick();
      rd_idx = 5'd31; #1; v1 = a_rd;
      tick(); rd_idx = 5'd31; #1;
      chk("R7 cycle step", a_rd, v1 + 64'd1);

      evt_valid = 1; evt_num = 16'h0011; repeat (3) tick(); evt_valid = 0;
      pk("R3 event count c0", 0, 64'd3, 64'd3);
      pk("R3 event count c4", 4, 64'd3, 64'd3);

      ev(16'h001E); ev(16'h0000);
      pk("R10 chain code ignored", 1, 64'd0, 64'd0);
      pk("R10 soft code ignored", 2, 64'd0, 64'd0);

      swinc_valid = 1; sw_mask = 32'h5; tick(); swinc_valid = 0;
      pk("R9 soft increment", 2, 64'd1, 64'd1);
      pk("R9 non-soft untouched", 0, 64'd3, 64'd3);

      ld(0, 64'h1_FFFF_FFFF);
      pk("R5 load width", 0, 64'hFFFF_FFFF, 64'h1_FFFF_FFFF);
      ev(16'h0011);
      pk("R6 wrap value", 0, 64'd0, 64'h2_0000_0000);
      pk("R8 chain carry", 1, 64'd1, 64'd1);
      chk("R6 status bit0 A", {63'b0, a_ov[0]}, 64'd1);
      chk("R6 status bit0 B", {63'b0, b_ov[0]}, 64'd1);

      evt_long = 1;
      ld(4, 64'hFFFF_FFFF);
      ev(16'h0011);
      pk("R6 long mode c4", 4, 64'd0, 64'h1_0000_0000);
      chk("R6 short wrap status A", {63'b0, a_ov[4]}, 64'd1);
      chk("R6 long no status B", {63'b0, b_ov[4]}, 64'd0);
      ld(0, 64'hFFFF_FFFF_FFFF_FFFF);
      ev(16'h0011);
      pk("R8 long blocks chain", 1, 64'd2, 64'd1);
      pk("R6 long wrap c0", 0, 64'd0, 64'd0);
      evt_long = 0;

      cnt_wr = 1; wr_idx = 5'd0; cnt_wdata = 64'd5; evt_valid = 1; evt_num = 16'h0011;
      tick(); cnt_wr = 0; evt_valid = 0;
      pk("R11 load priority", 0, 64'd5, 64'd5);

      ld(31, 64'hFFFF_FFFF);
      pk("R7 cycle load", 31, 64'hFFFF_FFFF, 64'hFFFF_FFFF);
      chk("R7 status before wrap", {63'b0, a_ov[31]}, 64'd0);
      tick();
      pk("R7 cycle wide", 31, 64'h1_0000_0000, 64'h1_0000_0000);
      chk("R7 cycle overflow status", {63'b0, a_ov[31]}, 64'd1);

      en_wr = 1; en_set = 0; en_mask = 32'h1; tick(); en_wr = 0;
      ev(16'h0011);
      pk("R2 disabled counter holds", 0, 64'd5, 64'd5);

      for (int k = 0; k < 600; k++) begin
         int r;
         r = int'($urandom_range(0, 99));
         glb_en    = (r < 90);
         evt_valid = ($urandom_range(0, 2) != 0);
         case ($urandom_range(0, 4))
            0: evt_num = 16'h0011;
            1: evt_num = 16'h001E;
            2: evt_num = 16'h0000;
            3: evt_num = 16'h0234;
            default: evt_num = 16'h1234;
         endcase
         swinc_valid = ($urandom_range(0, 3) == 0);
         sw_mask     = $urandom;
         en_wr       = ($urandom_range(0, 9) == 0);
         en_set      = ($urandom_range(0, 3) != 0);
         en_mask     = $urandom;
         wr_idx      = ($urandom_range(0, 7) == 0) ? 5'd31 : 5'(int'($urandom_range(0, 6)));
         typ_wr      = ($urandom_range(0, 11) == 0);
         case ($urandom_range(0, 3))
            0: typ_wdata = 16'h0000;
            1: typ_wdata = 16'h001E;
            2: typ_wdata = 16'h0011;
            default: typ_wdata = 16'h1234;
         endcase
         cnt_wr = ($urandom_range(0, 9) == 0);
         case ($urandom_range(0, 2))
            0: cnt_wdata = 64'hFFFF_FFFF - 64'($urandom_range(0, 3));
            1: cnt_wdata = 64'hFFFF_FFFF_FFFF_FFFF - 64'($urandom_range(0, 3));
            default: cnt_wdata = {32'($urandom), 32'hFFFF_FFFE};
         endcase
         if ($urandom_range(0, 19) == 0) evt_long = ~evt_long;
         if ($urandom_range(0, 19) == 0) cyc_long = ~cyc_long;
         rd_idx = 5'($urandom);
         tick();
      end
      glb_en = 0; evt_valid = 0; swinc_valid = 0; en_wr = 0; typ_wr = 0; cnt_wr = 0;
      tick(); tick();
      done = 1;
      summary();
      $finish;
   end
endmodule